// File: doc/BRIEF.md
# Display Run-State and Interrupt Gate

This block keeps track of whether a display refresh engine is running. It also turns two sticky status bits into one interrupt request. Software drives an enable level and a graceful-stop request level. The frame engine reports two single-cycle events: the start of a frame and the end of a frame. The block answers with an active flag that keeps the pixel pipeline going.

There are two ways to stop the engine. Dropping the enable stops it in the next cycle and leaves no trace in the status bits. Raising the graceful-stop request lets the frame in flight run to its end-of-frame pulse. At that point the engine halts and a disable-done status bit is latched.

Each status bit has its own mask bit. A mask only gates that bit's contribution to the interrupt. Status bits are cleared by a one-cycle write-one-to-clear strobe, one strobe per bit.

Top module: `disp_run_irq`

## Requirements
- R1: While the frame-start status bit is 1 and its mask input is 0, the interrupt output is 1. While that mask is 1, the frame-start status bit does not contribute to the interrupt.
- R2: Neither mask input changes a status bit. A status bit still sets on its event and clears on its strobe whatever its mask holds.
- R3: While running, a graceful-stop request keeps the active flag at 1 until the next end-of-frame pulse. In the cycle after that pulse the active flag is 0 and the disable-done status bit is 1.
- R4: While disable-done status is 1 and its mask input is 0, the interrupt output is 1. While that mask is 1, disable-done does not contribute to the interrupt.
- R5: If enable drops while running or while waiting for the frame end, the active flag is 0 in the next cycle and disable-done is not set.
- R6: Disable-done is set only by an end-of-frame pulse that ends a graceful stop. An end-of-frame pulse during normal running leaves it at 0.
- R7: Each status bit is cleared by a 1 on its clear strobe. If its set event and its clear strobe arrive in the same cycle, the bit ends at 1.
- R8: The interrupt output is a register. It is 0 after reset. It equals the OR of (status AND NOT mask) over both sources, taken one cycle earlier.
- R9: A graceful-stop request while the engine is stopped has no effect. The active flag stays 0, even when enable is 1, and disable-done is not set by an end-of-frame pulse.
- R10: When enable is 1 and no graceful-stop request is present, the active flag becomes 1 one cycle later. The frame-start status bit is set only by a frame-start pulse seen while the active flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable level; 0 stops the engine at once |
| gdis_req_i | input | 1 | Graceful-stop request level |
| sof_pulse_i | input | 1 | Frame-start event, one cycle |
| eof_pulse_i | input | 1 | Frame-end event, one cycle |
| sof_mask_i | input | 1 | 1 masks frame-start status from the interrupt |
| dd_mask_i | input | 1 | 1 masks disable-done status from the interrupt |
| sof_w1c_i | input | 1 | Clear strobe for frame-start status |
| dd_w1c_i | input | 1 | Clear strobe for disable-done status |
| active_o | output | 1 | Engine running flag for the pixel pipeline |
| sof_stat_o | output | 1 | Frame-start status bit |
| dd_stat_o | output | 1 | Disable-done status bit |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drops enable in the middle of a graceful drain. A design that lets the graceful path win there would latch disable-done on a quick stop.

It also sends end-of-frame pulses while running normally and while stopped with a stop request pending. A design that set disable-done on any frame end, or left the idle state on a request, would raise a false done.

Masks are toggled while a status bit is held. A design that cleared status through the mask would lose the bit.

A set and a clear are sent in the same cycle. A design that gave the clear priority would drop the event.

// File: rtl/disp_run_irq.sv
module disp_run_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic gdis_req_i,
  input  logic sof_pulse_i,
  input  logic eof_pulse_i,
  input  logic sof_mask_i,
  input  logic dd_mask_i,
  input  logic sof_w1c_i,
  input  logic dd_w1c_i,
  output logic active_o,
  output logic sof_stat_o,
  output logic dd_stat_o,
  output logic irq_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} run_t;

  run_t state_q, state_d;
  logic dd_evt;
  logic sof_q, dd_q, irq_q;

  always_comb begin
    state_d = state_q;
    dd_evt  = 1'b0;
    case (state_q)
      ST_IDLE:  if (en_i && !gdis_req_i) state_d = ST_RUN;
      ST_RUN:   if (!en_i) state_d = ST_IDLE;
                else if (gdis_req_i) state_d = ST_DRAIN;
      ST_DRAIN: if (!en_i) state_d = ST_IDLE;
                else if (eof_pulse_i) begin
                  state_d = ST_IDLE;
                  dd_evt  = 1'b1;
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  assign active_o = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sof_q   <= 1'b0;
      dd_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sof_q   <= (sof_pulse_i && active_o) || (sof_q && !sof_w1c_i);
      dd_q    <= dd_evt || (dd_q && !dd_w1c_i);
      irq_q   <= (sof_q && !sof_mask_i) || (dd_q && !dd_mask_i);
    end
  end

  assign sof_stat_o = sof_q;
  assign dd_stat_o  = dd_q;
  assign irq_o      = irq_q;

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_mask_i && dd_mask_i) |=> !irq_o); // R1
  AST_MASK_KEEPS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_pulse_i && !sof_w1c_i) |=> $stable(sof_stat_o)); // R2
  AST_DD_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dd_stat_o) |-> ($past(eof_pulse_i) && $past(en_i) && !active_o)); // R6
  AST_QUICK_NO_DD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !en_i) |=> (!active_o && !$rose(dd_stat_o))); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse_i && active_o) |=> sof_stat_o); // R7
  AST_IDLE_REQ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && gdis_req_i) |=> (!active_o && !$rose(dd_stat_o))); // R9
  AST_DD_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (dd_stat_o && !dd_mask_i) |=> irq_o); // R4

endmodule

// File: tb/disp_run_irq_tb_top.sv
module disp_run_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, gdis_req_i = 0, sof_pulse_i = 0, eof_pulse_i = 0;
  logic sof_mask_i = 0, dd_mask_i = 0, sof_w1c_i = 0, dd_w1c_i = 0;
  logic active_o, sof_stat_o, dd_stat_o, irq_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  disp_run_irq dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .gdis_req_i(gdis_req_i),
    .sof_pulse_i(sof_pulse_i), .eof_pulse_i(eof_pulse_i),
    .sof_mask_i(sof_mask_i), .dd_mask_i(dd_mask_i),
    .sof_w1c_i(sof_w1c_i), .dd_w1c_i(dd_w1c_i),
    .active_o(active_o), .sof_stat_o(sof_stat_o),
    .dd_stat_o(dd_stat_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    sof_pulse_i = 0; eof_pulse_i = 0; sof_w1c_i = 0; dd_w1c_i = 0;
  endtask

  task automatic t_reset();
    chk("R8", "reset active", active_o, 0);
    chk("R8", "reset sof", sof_stat_o, 0);
    chk("R8", "reset dd", dd_stat_o, 0);
    chk("R8", "reset irq", irq_o, 0);
  endtask

  task automatic t_start();
    en_i = 1; gdis_req_i = 0;
    chk("R10", "active before edge", active_o, 0);
    step();
    chk("R10", "active after enable", active_o, 1);
  endtask

  task automatic t_sof_irq();
    sof_mask_i = 0; sof_pulse_i = 1; step();
    chk("R10", "sof set while active", sof_stat_o, 1);
    chk("R8", "irq lags status", irq_o, 0);
    step();
    chk("R1", "sof unmasked irq", irq_o, 1);
    sof_w1c_i = 1; step();
    chk("R7", "sof cleared", sof_stat_o, 0);
    chk("R8", "irq still from old status", irq_o, 1);
    step();
    chk("R8", "irq drops", irq_o, 0);
  endtask

  task automatic t_sof_masked();
    sof_mask_i = 1; sof_pulse_i = 1; step();
    chk("R2", "masked sof still sets", sof_stat_o, 1);
    step();
    chk("R1", "masked sof no irq", irq_o, 0);
    sof_mask_i = 0; step(); step();
    chk("R1", "unmask raises irq", irq_o, 1);
    sof_mask_i = 1; step(); step();
    chk("R1", "remask drops irq", irq_o, 0);
    chk("R2", "remask keeps sof", sof_stat_o, 1);
    sof_w1c_i = 1; step();
    chk("R2", "clear works while masked", sof_stat_o, 0);
    sof_mask_i = 0;
  endtask

  task automatic t_set_wins();
    sof_pulse_i = 1; sof_w1c_i = 1; step();
    chk("R7", "set beats clear", sof_stat_o, 1);
    sof_w1c_i = 1; step(); step();
  endtask

  task automatic t_eof_running();
    eof_pulse_i = 1; step();
    chk("R6", "eof while running no dd", dd_stat_o, 0);
    chk("R6", "still active", active_o, 1);
  endtask

  task automatic t_graceful();
    dd_mask_i = 0; gdis_req_i = 1; step();
    chk("R3", "active during drain", active_o, 1);
    step(); step();
    chk("R3", "active until eof", active_o, 1);
    chk("R3", "no dd before eof", dd_stat_o, 0);
    eof_pulse_i = 1; step();
    chk("R3", "stopped at eof", active_o, 0);
    chk("R3", "dd set at eof", dd_stat_o, 1);
    step();
    chk("R4", "dd unmasked irq", irq_o, 1);
    dd_mask_i = 1; step(); step();
    chk("R4", "dd masked no irq", irq_o, 0);
    chk("R2", "dd kept under mask", dd_stat_o, 1);
    dd_w1c_i = 1; step();
    chk("R7", "dd cleared", dd_stat_o, 0);
    dd_mask_i = 0;
    chk("R9", "stays stopped with request held", active_o, 0);
    en_i = 0; gdis_req_i = 0; step(); step();
  endtask

  task automatic t_quick();
    en_i = 1; step();
    chk("R10", "restart", active_o, 1);
    en_i = 0; step();
    chk("R5", "quick stop", active_o, 0);
    chk("R5", "quick stop no dd", dd_stat_o, 0);
    en_i = 1; step();
    gdis_req_i = 1; step();
    chk("R3", "draining", active_o, 1);
    en_i = 0; step();
    chk("R5", "quick stop in drain", active_o, 0);
    chk("R5", "drain quick no dd", dd_stat_o, 0);
    step();
    chk("R5", "no irq after quick", irq_o, 0);
    gdis_req_i = 0;
  endtask

  task automatic t_idle_req();
    en_i = 0; gdis_req_i = 1; eof_pulse_i = 1; step();
    chk("R9", "idle request no dd", dd_stat_o, 0);
    en_i = 1; step();
    chk("R9", "request blocks start", active_o, 0);
    eof_pulse_i = 1; step();
    chk("R9", "idle eof no dd", dd_stat_o, 0);
    sof_pulse_i = 1; step();
    chk("R10", "sof ignored when stopped", sof_stat_o, 0);
    en_i = 0; gdis_req_i = 0; step();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_start();
        t_sof_irq();
        t_sof_masked();
        t_set_wins();
        t_eof_running();
        t_graceful();
        t_quick();
        t_idle_req();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule